// File: doc/BRIEF.md
# Authenticated Write Staging Buffer

This block is the eight-byte staging area between a byte-level command decoder and a protected memory. A write command loads a two-byte target address and up to eight data bytes. The stored address is forced onto an eight-byte boundary. The running CRC-16 still covers the address bytes exactly as they arrived, and its inverted value can be fetched once the buffer is full. A read command replays both address bytes, then a status byte, then the eight data bytes.

The status byte carries two live flags. Bit 5 marks contents that cannot be trusted: a byte received short of eight bits, a power-loss indication, or the state after reset. Bit 7 marks contents that have already been committed. All other status bits read as one.

A copy command must be followed by the current values of the first address byte, the second address byte and the status byte, in that order. A commit is issued only if all three match and the external MAC-accepted input is high when the third byte arrives. The commit presents the aligned address and all eight data bytes for one cycle.

Top module: `sbuf_top`

## Requirements
- R1: After reset, no commit and no transmit strobe are active. A read returns address bytes 0x00 and 0x00 and status 0x7F, so the untrusted flag is set and the committed flag is clear.
- R2: The first address byte is stored with bits [2:0] forced to 0. The second address byte is stored unchanged. A commit address always has bits [2:0] equal to 0.
- R3: Status bits 6, 4, 3, 2, 1 and 0 always read 1. Bit 7 is the committed flag and bit 5 is the untrusted flag.
- R4: Receiving a byte of fewer than 8 bits during a write sets the untrusted flag. Starting a write clears it.
- R5: A one-cycle power-loss pulse sets the untrusted flag from the next cycle on, and this takes priority over a write start.
- R6: Starting a write clears the committed flag. A successful commit sets it in the same cycle that the commit strobe rises.
- R7: After a read command, each transmit request returns the next byte one cycle later with tx_valid high. The order is first address byte, second address byte, status, then data bytes 0 to 7. Any request after that returns 0xFF.
- R8: On a copy, if the three bytes equal the stored first address byte, second address byte and status, and mac_ok is high with the third byte, then commit_valid is high for exactly one cycle. commit_addr is {second, first} and commit_data holds data byte k in bits [8k+7:8k].
- R9: A copy whose three bytes differ from the stored values in any position, or whose mac_ok is low with the third byte, produces no commit and leaves the committed flag clear.
- R10: Once a write has received the address and eight data bytes, the first transmit request returns the low byte and the second returns the high byte of the inverted CRC-16. The CRC uses polynomial x^16+x^15+x^2+1, starts from zero, and takes bits LSB first over the command byte, both address bytes as received, and the data bytes.
- R11: Full bytes received after the eighth data byte of a write do not change the stored data or the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_lost | input | 1 | Power-loss indication pulse |
| cmd_start | input | 1 | Starts a command |
| cmd_op | input | 2 | Command: 1 write, 2 read, 3 copy, 0 none |
| cmd_byte | input | 8 | Command code byte, included in the write CRC |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_bits | input | 4 | Number of valid bits in rx_data (8 means a full byte) |
| mac_ok | input | 1 | MAC accepted, sampled with the third copy byte |
| tx_req | input | 1 | Request for the next outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_addr | output | 16 | Aligned target address |
| commit_data | output | 64 | Eight staged data bytes |

## Verification
The write path is driven with an address whose low three bits are not zero, so the aligned stored copy and the unaligned CRC input can be told apart. Surplus bytes after a full write show whether the buffer and the CRC really stop. Short bytes and power-loss pulses are checked separately from write starts, to separate setting the untrusted flag from clearing it. Copies are tried in three forms: with the correct pattern, with the raw unaligned first byte, and with the correct pattern but MAC refused. These show that all three pattern bytes and the MAC input gate the commit.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam logic [1:0] OP_NONE  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_COPY  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_COPY  = 2'd3
  } sbuf_state_e;

  // Reflected form of x^16+x^15+x^2+1, one byte absorbed LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sbuf_crc16.sv
module sbuf_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_en,
  input  logic        step_en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import sbuf_pkg::*;
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (seed_en)      crc_d = crc16_step(16'h0000, din);
    else if (step_en) crc_d = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 16'h0000;
    else if (seed_en || step_en) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sbuf_status.sv
module sbuf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_lost,
  input  logic       wr_start,
  input  logic       partial,
  input  logic       commit,
  output logic       pf,
  output logic       aa,
  output logic [7:0] es
);
  logic pf_q, pf_d, aa_q, aa_d;

  always_comb begin
    pf_d = pf_q;
    if (pwr_lost)      pf_d = 1'b1;
    else if (wr_start) pf_d = 1'b0;
    else if (partial)  pf_d = 1'b1;
    aa_d = aa_q;
    if (wr_start)    aa_d = 1'b0;
    else if (commit) aa_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b1;
      aa_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
      aa_q <= aa_d;
    end
  end

  assign pf = pf_q;
  assign aa = aa_q;
  assign es = {aa_q, 1'b1, pf_q, 5'b11111};

  p_pf_on_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost |=> pf_q);
  p_aa_clear_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !aa_q);
  p_pf_clear_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !pwr_lost) |=> !pf_q);
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
  parameter int DATA_BYTES = 8,
  parameter int ALIGN_BITS = 3,
  localparam int IDX_W = $clog2(DATA_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ta1_we,
  input  logic                    ta2_we,
  input  logic                    d_we,
  input  logic [IDX_W-1:0]        d_idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              ta1,
  output logic [7:0]              ta2,
  output logic [8*DATA_BYTES-1:0] data
);
  logic [7:0] ta1_q, ta2_q;
  logic [7:0] ta1_aligned;

  assign ta1_aligned = {wdata[7:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta1_q <= 8'h00;
      ta2_q <= 8'h00;
    end else begin
      if (ta1_we) ta1_q <= ta1_aligned;
      if (ta2_we) ta2_q <= wdata;
    end
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    logic [7:0] b_q;
    logic       b_en;
    assign b_en = d_we && (d_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= 8'h00;
      else if (b_en) b_q <= wdata;
    end
    assign data[8*k +: 8] = b_q;
  end

  assign ta1 = ta1_q;
  assign ta2 = ta2_q;
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top #(
  parameter int DATA_BYTES = 8,
  parameter int ALIGN_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_lost,
  input  logic                    cmd_start,
  input  logic [1:0]              cmd_op,
  input  logic [7:0]              cmd_byte,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic [3:0]              rx_bits,
  input  logic                    mac_ok,
  input  logic                    tx_req,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  output logic                    commit_valid,
  output logic [15:0]             commit_addr,
  output logic [8*DATA_BYTES-1:0] commit_data
);
  import sbuf_pkg::*;

  localparam int IDX_W  = $clog2(DATA_BYTES);
  localparam int CNT_W  = $clog2(DATA_BYTES + 3) + 1;
  localparam int TPOS_W = $clog2(DATA_BYTES + 4) + 1;
  localparam logic [CNT_W-1:0]  WR_FULL  = CNT_W'(DATA_BYTES + 2);
  localparam logic [CNT_W-1:0]  CP_LAST  = CNT_W'(2);
  localparam logic [TPOS_W-1:0] RD_END   = TPOS_W'(DATA_BYTES + 3);

  sbuf_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TPOS_W-1:0] tpos_q, tpos_d;
  logic              match_q, match_d;
  logic              commit_q, commit_d;
  logic              txv_q;
  logic [7:0]        txd_q, txd_d;

  logic              full_byte, part_byte, wr_start;
  logic              ta1_we, ta2_we, d_we, crc_step;
  logic [IDX_W-1:0]  d_idx;
  logic [7:0]        ta1, ta2, es;
  logic [15:0]       crc;
  logic              pf, aa;
  logic [8*DATA_BYTES-1:0] data;
  logic [7:0]        cp_expect, rd_byte;
  logic [TPOS_W-1:0] rd_off;

  assign full_byte = rx_valid && (rx_bits == 4'd8) && !cmd_start;
  assign part_byte = rx_valid && (rx_bits != 4'd8) && !cmd_start;
  assign wr_start  = cmd_start && (cmd_op == OP_WRITE);

  // Write path enables
  always_comb begin
    ta1_we = 1'b0;
    ta2_we = 1'b0;
    d_we   = 1'b0;
    crc_step = 1'b0;
    d_idx  = '0;
    if (state_q == ST_WRITE && full_byte && cnt_q < WR_FULL) begin
      crc_step = 1'b1;
      if (cnt_q == CNT_W'(0))      ta1_we = 1'b1;
      else if (cnt_q == CNT_W'(1)) ta2_we = 1'b1;
      else begin
        d_we  = 1'b1;
        d_idx = IDX_W'(cnt_q - CNT_W'(2));
      end
    end
  end

  // Copy pattern byte expected at the current position
  always_comb begin
    case (cnt_q)
      CNT_W'(0): cp_expect = ta1;
      CNT_W'(1): cp_expect = ta2;
      default:   cp_expect = es;
    endcase
  end

  // Replay byte for reads
  always_comb begin
    rd_off  = tpos_q - TPOS_W'(3);
    rd_byte = 8'hFF;
    if (tpos_q == TPOS_W'(0))      rd_byte = ta1;
    else if (tpos_q == TPOS_W'(1)) rd_byte = ta2;
    else if (tpos_q == TPOS_W'(2)) rd_byte = es;
    else if (tpos_q < RD_END)      rd_byte = data[8*rd_off +: 8];
  end

  // Sequencer next state
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tpos_d   = tpos_q;
    match_d  = match_q;
    commit_d = 1'b0;
    txd_d    = 8'hFF;
    if (cmd_start) begin
      case (cmd_op)
        OP_WRITE: state_d = ST_WRITE;
        OP_READ:  state_d = ST_READ;
        OP_COPY:  state_d = ST_COPY;
        default:  state_d = ST_IDLE;
      endcase
      cnt_d   = '0;
      tpos_d  = '0;
      match_d = 1'b1;
    end else begin
      case (state_q)
        ST_WRITE: begin
          if (full_byte && cnt_q < WR_FULL) cnt_d = cnt_q + CNT_W'(1);
          if (tx_req) begin
            if (cnt_q == WR_FULL) begin
              if (tpos_q == TPOS_W'(0))      txd_d = ~crc[7:0];
              else if (tpos_q == TPOS_W'(1)) txd_d = ~crc[15:8];
              if (tpos_q < TPOS_W'(2))       tpos_d = tpos_q + TPOS_W'(1);
            end
          end
        end
        ST_READ: begin
          if (tx_req) begin
            txd_d = rd_byte;
            if (tpos_q < RD_END) tpos_d = tpos_q + TPOS_W'(1);
          end
        end
        ST_COPY: begin
          if (part_byte && cnt_q <= CP_LAST) match_d = 1'b0;
          if (full_byte && cnt_q <= CP_LAST) begin
            cnt_d   = cnt_q + CNT_W'(1);
            match_d = match_q && (rx_data == cp_expect);
            if (cnt_q == CP_LAST)
              commit_d = match_q && (rx_data == cp_expect) && mac_ok;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      tpos_q   <= '0;
      match_q  <= 1'b0;
      commit_q <= 1'b0;
      txv_q    <= 1'b0;
      txd_q    <= 8'hFF;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tpos_q   <= tpos_d;
      match_q  <= match_d;
      commit_q <= commit_d;
      txv_q    <= tx_req;
      if (tx_req) txd_q <= txd_d;
    end
  end

  sbuf_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed_en (wr_start),
    .step_en (crc_step),
    .din     (wr_start ? cmd_byte : rx_data),
    .crc     (crc)
  );

  sbuf_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_lost (pwr_lost),
    .wr_start (wr_start),
    .partial  (part_byte && state_q == ST_WRITE),
    .commit   (commit_d),
    .pf       (pf),
    .aa       (aa),
    .es       (es)
  );

  sbuf_store #(.DATA_BYTES(DATA_BYTES), .ALIGN_BITS(ALIGN_BITS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ta1_we (ta1_we),
    .ta2_we (ta2_we),
    .d_we   (d_we),
    .d_idx  (d_idx),
    .wdata  (rx_data),
    .ta1    (ta1),
    .ta2    (ta2),
    .data   (data)
  );

  assign tx_valid     = txv_q;
  assign tx_data      = txd_q;
  assign commit_valid = commit_q;
  assign commit_addr  = {ta2, ta1};
  assign commit_data  = data;

  p_commit_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  p_aa_with_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> aa);
  p_commit_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (commit_addr[ALIGN_BITS-1:0] == '0));
  p_tx_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txv_q |-> $past(tx_req));
  p_status_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (es & 8'h5F) == 8'h5F);
endmodule

// File: tb/sbuf_top_tb.sv
module sbuf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_lost, cmd_start, rx_valid, mac_ok, tx_req;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte, rx_data;
  logic [3:0]  rx_bits;
  logic        tx_valid, commit_valid;
  logic [7:0]  tx_data;
  logic [15:0] commit_addr;
  logic [63:0] commit_data;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sbuf_top dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bits(rx_bits), .mac_ok(mac_ok), .tx_req(tx_req), .tx_valid(tx_valid),
    .tx_data(tx_data), .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  logic [7:0] wdat [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial CRC-16 (x^16+x^15+x^2+1), zero seed, LSB first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] s = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = s[0] ^ b[i];
      s = {1'b0, s[15:1]};
      if (fb) s = s ^ 16'hA001;
    end
    return s;
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [7:0] cb);
    cmd_start = 1'b1; cmd_op = op; cmd_byte = cb;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic [3:0] bits);
    rx_valid = 1'b1; rx_data = b; rx_bits = bits;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fetch(output logic [7:0] b);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    b = tx_data;
    check(tx_valid === 1'b1, "R7 tx_valid", {63'd0, tx_valid}, 64'd1);
  endtask

  task automatic read_es(output logic [7:0] es);
    logic [7:0] d;
    cmd(2'd2, 8'hAA);
    fetch(d); fetch(d); fetch(es);
  endtask

  task automatic full_write(input logic [7:0] a1, input logic [7:0] a2);
    cmd(2'd1, 8'h0F);
    send(a1, 4'd8); send(a2, 4'd8);
    for (int i = 0; i < 8; i++) send(wdat[i], 4'd8);
  endtask

  task automatic t_reset;
    logic [7:0] b;
    check(commit_valid === 1'b0 && tx_valid === 1'b0, "R1 outputs idle", {62'd0, commit_valid, tx_valid}, 64'd0);
    cmd(2'd2, 8'hAA);
    fetch(b); check(b === 8'h00, "R1 ta1", b, 8'h00);
    fetch(b); check(b === 8'h00, "R1 ta2", b, 8'h00);
    fetch(b); check(b === 8'h7F, "R1 status", b, 8'h7F);
  endtask

  task automatic t_write_read;
    logic [7:0] b;
    full_write(8'h2D, 8'h01);
    cmd(2'd2, 8'hAA);
    fetch(b); check(b === 8'h28, "R2 ta1 aligned", b, 8'h28);
    fetch(b); check(b === 8'h01, "R2 ta2 kept", b, 8'h01);
    fetch(b); check(b === 8'h5F, "R4 status after write", b, 8'h5F);
    check((b & 8'h5F) === 8'h5F, "R3 fixed ones", b, 8'h5F);
    for (int i = 0; i < 8; i++) begin
      fetch(b); check(b === wdat[i], "R7 data order", b, wdat[i]);
    end
    fetch(b); check(b === 8'hFF, "R7 past end", b, 8'hFF);
  endtask

  task automatic t_crc_overrun;
    logic [15:0] c;
    logic [7:0]  lo, hi, b;
    c = ref_crc(16'h0, 8'h0F);
    c = ref_crc(c, 8'h2D);
    c = ref_crc(c, 8'h01);
    for (int i = 0; i < 8; i++) c = ref_crc(c, wdat[i]);
    full_write(8'h2D, 8'h01);
    send(8'hEE, 4'd8);
    fetch(lo); fetch(hi);
    check({hi, lo} === ~c, "R10 inverted crc low first", {hi, lo}, ~c);
    check({hi, lo} === ~c, "R11 crc unchanged by surplus", {hi, lo}, ~c);
    cmd(2'd2, 8'hAA);
    for (int i = 0; i < 3; i++) fetch(b);
    for (int i = 0; i < 8; i++) begin
      fetch(b); check(b === wdat[i], "R11 data kept", b, wdat[i]);
    end
  endtask

  task automatic t_partial;
    logic [7:0] es;
    cmd(2'd1, 8'h0F);
    send(8'h40, 4'd8);
    send(8'h05, 4'd3);
    read_es(es); check(es === 8'h7F, "R4 partial sets flag", es, 8'h7F);
    full_write(8'h40, 8'h00);
    read_es(es); check(es === 8'h5F, "R4 write clears flag", es, 8'h5F);
  endtask

  task automatic t_power;
    logic [7:0] es;
    pwr_lost = 1'b1; @(negedge clk); pwr_lost = 1'b0;
    read_es(es); check(es === 8'h7F, "R5 power loss sets flag", es, 8'h7F);
  endtask

  task automatic t_copy_ok;
    logic [7:0] es;
    logic [63:0] exp_d;
    for (int i = 0; i < 8; i++) exp_d[8*i +: 8] = wdat[i];
    full_write(8'h2D, 8'h01);
    mac_ok = 1'b1;
    cmd(2'd3, 8'h55);
    send(8'h28, 4'd8); send(8'h01, 4'd8); send(8'h5F, 4'd8);
    mac_ok = 1'b0;
    check(commit_valid === 1'b1, "R8 commit strobe", {63'd0, commit_valid}, 64'd1);
    check(commit_addr === 16'h0128, "R8 commit addr", commit_addr, 16'h0128);
    check(commit_data === exp_d, "R8 commit data", commit_data, exp_d);
    @(negedge clk);
    check(commit_valid === 1'b0, "R8 single cycle", {63'd0, commit_valid}, 64'd0);
    read_es(es); check(es === 8'hDF, "R6 committed flag set", es, 8'hDF);
    full_write(8'h2D, 8'h01);
    read_es(es); check(es === 8'h5F, "R6 write clears committed", es, 8'h5F);
  endtask

  task automatic t_copy_bad;
    logic [7:0] es;
    logic seen = 1'b0;
    mac_ok = 1'b1;
    cmd(2'd3, 8'h55);
    send(8'h2D, 4'd8); send(8'h01, 4'd8); send(8'h5F, 4'd8);
    seen = commit_valid;
    mac_ok = 1'b0;
    check(seen === 1'b0, "R9 raw address rejected", {63'd0, seen}, 64'd0);
    read_es(es); check(es === 8'h5F, "R9 flag stays clear", es, 8'h5F);
    cmd(2'd3, 8'h55);
    send(8'h28, 4'd8); send(8'h01, 4'd8); send(8'h5F, 4'd8);
    check(commit_valid === 1'b0, "R9 mac refused", {63'd0, commit_valid}, 64'd0);
    read_es(es); check(es === 8'h5F, "R9 flag clear after refusal", es, 8'h5F);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_lost = 1'b0; cmd_start = 1'b0; cmd_op = 2'd0; cmd_byte = 8'h00;
    rx_valid = 1'b0; rx_data = 8'h00; rx_bits = 4'd8; mac_ok = 1'b0; tx_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_crc_overrun();
    t_partial();
    t_power();
    t_copy_ok();
    t_copy_bad();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule